// File: doc/BRIEF.md
# Memory Scanner to CRC Controller

The block walks an address window, one word at a time, and streams the words it reads into a CRC engine. Software programs a starting (low) address, an ending (high) address and a control word. Each read is requested from a system arbiter. Once granted, the word is latched from the memory read port and passed to the CRC engine with a single-cycle valid strobe. The low address then steps up by one, and the walk repeats until the low address passes the high address.

Three request policies are available. In the paced policy a request is raised only while the CRC engine can take data. The triggered policy adds an external trigger as a further condition. In burst, a request is raised whenever the scan is armed. The go bit arms the scan and is cleared by hardware in three cases: when the window is used up, when the CRC engine's go input falls, or when the low address wraps past its all-ones value. A region bit chooses whether scan addresses point at data EEPROM or at program flash.

Top module: `mem_scan_crc_ctrl`

## Requirements
- R1: After reset the control word, the low address and the high address all read 0, and `arb_req` and `crc_valid` are 0.
- R2: With trigger-gating 0 and burst 0, `arb_req` is 1 exactly when enable and go are 1, the sequencer is idle, low <= high, and `crc_ready` is 1.
- R3: With trigger-gating 1 and burst 0, the condition of R2 additionally requires `scan_trig` to be 1.
- R4: With burst 1, `arb_req` is 1 whenever enable and go are 1, the sequencer is idle and low <= high, regardless of `crc_ready`, `scan_trig` and trigger-gating.
- R5: `arb_req` is 0 while enable or go is 0, and while a fetched word waits for the CRC engine.
- R6: In a cycle with `arb_req` and `arb_gnt` both 1, `mem_rdata` is captured. From the next cycle `crc_data` holds that word, and `crc_valid` is 1 for exactly one cycle in which `crc_ready` is 1. The low address is one higher after that cycle.
- R7: While a captured word waits and `crc_ready` is 0, `crc_valid` stays 0 and `crc_data` holds its value.
- R8: A control write with go = 1 sets go only if `crc_en` and `crc_go` are both 1. Otherwise go reads 0.
- R9: Go is cleared on the edge after any of these: `crc_go` is 0; low > high while idle (this also overrides a same-cycle software set); a hand-off at low = all ones; a control write with go = 0.
- R10: `mem_addr` equals the low address register and `mem_region` equals the region bit (1 = data EEPROM, 0 = program flash).
- R11: The busy bit reads 1 from the edge after a grant until the word is handed to the CRC engine, and reads 0 otherwise.
- R12: Writing a control word that differs from the current one only in enable = 0 leaves go, trigger-gating, region, burst, low and high unchanged, and stops requests.
- R13: Register select 0 is control, 1 is low address, 2 is high address. The control bits are enable bit 0, trigger-gating bit 1, go bit 2, region bit 3, burst bit 4 and busy bit 5 (read-only). Reads are combinational on `reg_rd_sel`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wr_sel | input | 2 | Register select for writes |
| reg_wr_data | input | ADDR_W | Write data |
| reg_rd_sel | input | 2 | Register select for reads |
| reg_rd_data | output | ADDR_W | Read data |
| arb_req | output | 1 | Memory access request to arbiter |
| arb_gnt | input | 1 | Arbiter grant |
| mem_addr | output | ADDR_W | Scan read address |
| mem_region | output | 1 | 1 = data EEPROM, 0 = program flash |
| mem_rdata | input | DATA_W | Memory read data, valid in grant cycle |
| crc_en | input | 1 | CRC engine enabled |
| crc_go | input | 1 | CRC engine running |
| crc_ready | input | 1 | CRC engine can accept a word |
| crc_valid | output | 1 | Word strobe to CRC engine |
| crc_data | output | DATA_W | Word to CRC engine |
| scan_trig | input | 1 | Selected external trigger |

## Verification
On every cycle the assertions check the request gating: no request without enable and go, the CRC-ready and trigger conditions outside burst, and no request while a word waits. They also check the strobe rules: valid only with ready, never on two cycles in a row, data held during a stall, and the address stepping by one after each hand-off. They further check that go drops after `crc_go` falls and that go only rises when the CRC inputs allowed it. Only the bench scenarios show the data values that travel from memory to the CRC engine, the register read-back encoding, go being cleared when the window runs out or the address wraps, and the disable write leaving the other fields in place.

// File: rtl/scan_pkg.sv
`timescale 1ns/1ps
package scan_pkg;

    typedef enum logic {
        SQ_IDLE = 1'b0,
        SQ_SEND = 1'b1
    } sq_state_e;

    // packed LSB first: en bit0, trig_en bit1, go bit2, region bit3, burst bit4
    typedef struct packed {
        logic burst;
        logic region;
        logic go;
        logic trig_en;
        logic en;
    } scan_ctrl_t;

    localparam int unsigned CTRL_FIELDS   = 5;
    localparam int unsigned CTRL_BUSY_BIT = 5;

    localparam logic [1:0] SEL_CTRL = 2'd0;
    localparam logic [1:0] SEL_LO   = 2'd1;
    localparam logic [1:0] SEL_HI   = 2'd2;

endpackage

// File: rtl/scan_regs.sv
`timescale 1ns/1ps
module scan_regs
    import scan_pkg::*;
#(
    parameter int unsigned ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        wr_sel,
    input  logic [ADDR_W-1:0] wr_data,
    input  logic [1:0]        rd_sel,
    output logic [ADDR_W-1:0] rd_data,
    input  logic              crc_en,
    input  logic              crc_go,
    input  logic              seq_idle,
    input  logic              step,
    output scan_ctrl_t        ctrl,
    output logic [ADDR_W-1:0] lo_addr,
    output logic [ADDR_W-1:0] hi_addr,
    output logic              exhausted
);

    localparam logic [ADDR_W-1:0] ADDR_ONE = ADDR_W'(1);

    typedef struct packed {
        scan_ctrl_t        ctrl;
        logic [ADDR_W-1:0] lo;
        logic [ADDR_W-1:0] hi;
    } regs_t;

    regs_t regs_d, regs_q;
    logic  wrap;
    logic  hw_clr;

    always_comb begin
        regs_d    = regs_q;
        exhausted = regs_q.lo > regs_q.hi;
        wrap      = step && (regs_q.lo == '1);
        hw_clr    = !crc_go || (exhausted && seq_idle) || wrap;

        if (step) begin
            regs_d.lo = regs_q.lo + ADDR_ONE;
        end

        if (wr_en) begin
            case (wr_sel)
                SEL_CTRL: begin
                    regs_d.ctrl.en      = wr_data[0];
                    regs_d.ctrl.trig_en = wr_data[1];
                    regs_d.ctrl.go      = wr_data[2] && crc_en && crc_go;
                    regs_d.ctrl.region  = wr_data[3];
                    regs_d.ctrl.burst   = wr_data[4];
                end
                SEL_LO:  regs_d.lo = wr_data;
                SEL_HI:  regs_d.hi = wr_data;
                default: ;
            endcase
        end

        if (hw_clr) begin
            regs_d.ctrl.go = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q <= '0;
        end else begin
            regs_q <= regs_d;
        end
    end

    always_comb begin
        rd_data = '0;
        case (rd_sel)
            SEL_CTRL: begin
                rd_data[CTRL_FIELDS-1:0] = regs_q.ctrl;
                rd_data[CTRL_BUSY_BIT]   = !seq_idle;
            end
            SEL_LO:  rd_data = regs_q.lo;
            SEL_HI:  rd_data = regs_q.hi;
            default: rd_data = '0;
        endcase
    end

    assign ctrl    = regs_q.ctrl;
    assign lo_addr = regs_q.lo;
    assign hi_addr = regs_q.hi;

endmodule

// File: rtl/scan_req_policy.sv
`timescale 1ns/1ps
module scan_req_policy
    import scan_pkg::*;
(
    input  scan_ctrl_t ctrl,
    input  logic       crc_ready,
    input  logic       trig,
    input  logic       exhausted,
    input  logic       seq_idle,
    output logic       req
);

    logic armed;
    logic want;

    always_comb begin
        armed = ctrl.en && ctrl.go && seq_idle && !exhausted;
        if (ctrl.burst) begin
            want = 1'b1;
        end else if (ctrl.trig_en) begin
            want = crc_ready && trig;
        end else begin
            want = crc_ready;
        end
        req = armed && want;
    end

endmodule

// File: rtl/scan_seq.sv
`timescale 1ns/1ps
module scan_seq
    import scan_pkg::*;
#(
    parameter int unsigned DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic              gnt,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic              crc_ready,
    output logic              crc_valid,
    output logic [DATA_W-1:0] crc_data,
    output logic              step,
    output logic              idle
);

    typedef struct packed {
        sq_state_e         st;
        logic [DATA_W-1:0] word;
    } seq_t;

    seq_t seq_d, seq_q;

    always_comb begin
        seq_d     = seq_q;
        crc_valid = 1'b0;
        step      = 1'b0;
        if (seq_q.st == SQ_IDLE) begin
            if (req && gnt) begin
                seq_d.st   = SQ_SEND;
                seq_d.word = mem_rdata;
            end
        end else begin
            if (crc_ready) begin
                crc_valid = 1'b1;
                step      = 1'b1;
                seq_d.st  = SQ_IDLE;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q <= '{st: SQ_IDLE, word: '0};
        end else begin
            seq_q <= seq_d;
        end
    end

    assign crc_data = seq_q.word;
    assign idle     = (seq_q.st == SQ_IDLE);

endmodule

// File: rtl/mem_scan_crc_ctrl.sv
`timescale 1ns/1ps
module mem_scan_crc_ctrl
    import scan_pkg::*;
#(
    parameter int unsigned ADDR_W = 16,
    parameter int unsigned DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr_en,
    input  logic [1:0]        reg_wr_sel,
    input  logic [ADDR_W-1:0] reg_wr_data,
    input  logic [1:0]        reg_rd_sel,
    output logic [ADDR_W-1:0] reg_rd_data,
    output logic              arb_req,
    input  logic              arb_gnt,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_region,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic              crc_en,
    input  logic              crc_go,
    input  logic              crc_ready,
    output logic              crc_valid,
    output logic [DATA_W-1:0] crc_data,
    input  logic              scan_trig
);

    scan_ctrl_t        ctrl_q;
    logic [ADDR_W-1:0] lo_addr;
    logic [ADDR_W-1:0] hi_addr;
    logic              exhausted;
    logic              seq_idle;
    logic              seq_step;

    scan_regs #(.ADDR_W(ADDR_W)) regs_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (reg_wr_en),
        .wr_sel    (reg_wr_sel),
        .wr_data   (reg_wr_data),
        .rd_sel    (reg_rd_sel),
        .rd_data   (reg_rd_data),
        .crc_en    (crc_en),
        .crc_go    (crc_go),
        .seq_idle  (seq_idle),
        .step      (seq_step),
        .ctrl      (ctrl_q),
        .lo_addr   (lo_addr),
        .hi_addr   (hi_addr),
        .exhausted (exhausted)
    );

    scan_req_policy policy_i (
        .ctrl      (ctrl_q),
        .crc_ready (crc_ready),
        .trig      (scan_trig),
        .exhausted (exhausted),
        .seq_idle  (seq_idle),
        .req       (arb_req)
    );

    scan_seq #(.DATA_W(DATA_W)) seq_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .req       (arb_req),
        .gnt       (arb_gnt),
        .mem_rdata (mem_rdata),
        .crc_ready (crc_ready),
        .crc_valid (crc_valid),
        .crc_data  (crc_data),
        .step      (seq_step),
        .idle      (seq_idle)
    );

    assign mem_addr   = lo_addr;
    assign mem_region = ctrl_q.region;

endmodule

// File: rtl/scan_ctrl_checker.sv
`timescale 1ns/1ps
module scan_ctrl_checker
    import scan_pkg::*;
#(
    parameter int unsigned ADDR_W = 16,
    parameter int unsigned DATA_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              arb_req,
    input logic              arb_gnt,
    input logic              crc_ready,
    input logic              crc_valid,
    input logic [DATA_W-1:0] crc_data,
    input logic              crc_en,
    input logic              crc_go,
    input logic              scan_trig,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              reg_wr_en,
    input logic [1:0]        reg_wr_sel,
    input scan_ctrl_t        ctrl_q,
    input logic              seq_idle
);

    assert_req_armed_R5: assert property (@(posedge clk) disable iff (!rst_n)
        arb_req |-> (ctrl_q.en && ctrl_q.go && seq_idle));

    assert_paced_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (arb_req && !ctrl_q.burst) |-> crc_ready);

    assert_trig_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (arb_req && !ctrl_q.burst && ctrl_q.trig_en) |-> scan_trig);

    assert_valid_ready_R7: assert property (@(posedge clk) disable iff (!rst_n)
        crc_valid |-> crc_ready);

    assert_valid_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
        crc_valid |=> !crc_valid);

    assert_stall_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!seq_idle && !crc_ready) |=> $stable(crc_data));

    assert_addr_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (crc_valid && !(reg_wr_en && reg_wr_sel == SEL_LO))
        |=> (mem_addr == $past(mem_addr) + ADDR_W'(1)));

    assert_busy_after_grant_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (arb_req && arb_gnt) |=> !seq_idle);

    assert_go_drop_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !crc_go |=> !ctrl_q.go);

    assert_go_rise_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ctrl_q.go) |-> $past(crc_en && crc_go));

endmodule

bind mem_scan_crc_ctrl scan_ctrl_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .arb_req    (arb_req),
    .arb_gnt    (arb_gnt),
    .crc_ready  (crc_ready),
    .crc_valid  (crc_valid),
    .crc_data   (crc_data),
    .crc_en     (crc_en),
    .crc_go     (crc_go),
    .scan_trig  (scan_trig),
    .mem_addr   (mem_addr),
    .reg_wr_en  (reg_wr_en),
    .reg_wr_sel (reg_wr_sel),
    .ctrl_q     (ctrl_q),
    .seq_idle   (seq_idle)
);

// File: tb/mem_scan_crc_ctrl_tb_top.sv
`timescale 1ns/1ps
module mem_scan_crc_ctrl_tb_top;

    localparam int unsigned AW = 16;
    localparam int unsigned DW = 16;

    // control word bit values (R13)
    localparam logic [15:0] C_EN    = 16'h0001;
    localparam logic [15:0] C_TRIG  = 16'h0002;
    localparam logic [15:0] C_GO    = 16'h0004;
    localparam logic [15:0] C_REG   = 16'h0008;
    localparam logic [15:0] C_BURST = 16'h0010;
    localparam logic [15:0] C_BUSY  = 16'h0020;

    // vector: [5]en [4]trig_en [3]burst [2]crc_ready [1]scan_trig [0]expected arb_req
    localparam int NVEC = 10;
    localparam logic [5:0] VEC [0:NVEC-1] = '{
        6'b100101, // R2 paced, ready
        6'b100010, // R2 paced, not ready
        6'b110111, // R3 triggered, ready+trig
        6'b110100, // R3 triggered, no trig
        6'b110010, // R3 triggered, trig but not ready
        6'b101001, // R4 burst, nothing ready
        6'b111001, // R4 burst ignores trigger gating
        6'b101111, // R4 burst, all high
        6'b001110, // R5 disabled burst
        6'b000100  // R5 disabled paced
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          reg_wr_en = 1'b0;
    logic [1:0]    reg_wr_sel = 2'd0;
    logic [AW-1:0] reg_wr_data = '0;
    logic [1:0]    reg_rd_sel = 2'd0;
    logic [AW-1:0] reg_rd_data;
    logic          arb_req;
    logic          arb_gnt = 1'b0;
    logic [AW-1:0] mem_addr;
    logic          mem_region;
    logic [DW-1:0] mem_rdata;
    logic          crc_en = 1'b0;
    logic          crc_go = 1'b0;
    logic          crc_ready = 1'b0;
    logic          crc_valid;
    logic [DW-1:0] crc_data;
    logic          scan_trig = 1'b0;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    // memory model: content depends on region and address
    assign mem_rdata = mem_addr ^ (mem_region ? 16'hE000 : 16'hF000);

    mem_scan_crc_ctrl #(.ADDR_W(AW), .DATA_W(DW)) dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .reg_wr_en   (reg_wr_en),
        .reg_wr_sel  (reg_wr_sel),
        .reg_wr_data (reg_wr_data),
        .reg_rd_sel  (reg_rd_sel),
        .reg_rd_data (reg_rd_data),
        .arb_req     (arb_req),
        .arb_gnt     (arb_gnt),
        .mem_addr    (mem_addr),
        .mem_region  (mem_region),
        .mem_rdata   (mem_rdata),
        .crc_en      (crc_en),
        .crc_go      (crc_go),
        .crc_ready   (crc_ready),
        .crc_valid   (crc_valid),
        .crc_data    (crc_data),
        .scan_trig   (scan_trig)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // returns at a falling edge; the write has landed on the rising edge before it
    task automatic wr(input logic [1:0] sel, input logic [15:0] data);
        @(negedge clk);
        reg_wr_en   = 1'b1;
        reg_wr_sel  = sel;
        reg_wr_data = data;
        @(negedge clk);
        reg_wr_en   = 1'b0;
    endtask

    task automatic rd_chk(input string tag, input logic [1:0] sel, input logic [15:0] exp);
        reg_rd_sel = sel;
        #0.1;
        check(tag, {16'h0, reg_rd_data}, {16'h0, exp});
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        #1;
        // R1 reset state
        rd_chk("R1 ctrl", 2'd0, 16'h0000);
        rd_chk("R1 lo", 2'd1, 16'h0000);
        rd_chk("R1 hi", 2'd2, 16'h0000);
        check("R1 arb_req", {31'b0, arb_req}, 32'd0);
        check("R1 crc_valid", {31'b0, crc_valid}, 32'd0);
        @(negedge clk);
        rst_n = 1'b1;

        // vector table: request policy
        crc_en = 1'b1;
        crc_go = 1'b1;
        wr(2'd1, 16'h0000);
        wr(2'd2, 16'h0005);
        for (int i = 0; i < NVEC; i++) begin
            crc_ready = VEC[i][2];
            scan_trig = VEC[i][1];
            wr(2'd0, (VEC[i][5] ? C_EN : 16'h0) | (VEC[i][4] ? C_TRIG : 16'h0) |
                     (VEC[i][3] ? C_BURST : 16'h0) | C_GO);
            #1;
            check($sformatf("R2/R3/R4/R5 vector %0d arb_req", i), {31'b0, arb_req}, {31'b0, VEC[i][0]});
        end
        wr(2'd0, 16'h0000);
        scan_trig = 1'b0;

        // R6 R10 R11 R13 paced transfers, region = EEPROM
        crc_ready = 1'b1;
        wr(2'd1, 16'h0002);
        wr(2'd2, 16'h0003);
        wr(2'd0, C_EN | C_GO | C_REG);
        arb_gnt = 1'b1;
        #1;
        check("R2 req before grant", {31'b0, arb_req}, 32'd1);
        check("R10 mem_addr", {16'h0, mem_addr}, 32'h2);
        check("R10 mem_region", {31'b0, mem_region}, 32'd1);
        @(negedge clk); #1;
        check("R6 crc_valid", {31'b0, crc_valid}, 32'd1);
        check("R6 crc_data", {16'h0, crc_data}, 32'hE002);
        check("R5 no req while waiting", {31'b0, arb_req}, 32'd0);
        rd_chk("R11 R13 busy read", 2'd0, C_EN | C_GO | C_REG | C_BUSY);
        @(negedge clk); #1;
        check("R6 single pulse", {31'b0, crc_valid}, 32'd0);
        check("R6 addr step", {16'h0, mem_addr}, 32'h3);
        rd_chk("R11 busy clear", 2'd0, C_EN | C_GO | C_REG);
        @(negedge clk); #1;
        check("R6 second word", {16'h0, crc_data}, 32'hE003);
        check("R6 second valid", {31'b0, crc_valid}, 32'd1);
        @(negedge clk);
        arb_gnt = 1'b0;
        #1;
        check("R2 no req past window", {31'b0, arb_req}, 32'd0);
        @(negedge clk); #1;
        rd_chk("R9 window exhausted clears go", 2'd0, C_EN | C_REG);
        rd_chk("R6 lo final", 2'd1, 16'h0004);

        // R4 R7 burst stall, region = flash
        crc_ready = 1'b0;
        wr(2'd1, 16'h0000);
        wr(2'd2, 16'h0001);
        wr(2'd0, C_EN | C_GO | C_BURST);
        arb_gnt = 1'b1;
        #1;
        check("R4 burst req not ready", {31'b0, arb_req}, 32'd1);
        check("R10 flash region", {31'b0, mem_region}, 32'd0);
        @(negedge clk);
        arb_gnt = 1'b0;
        #1;
        check("R7 stalled valid", {31'b0, crc_valid}, 32'd0);
        check("R7 stalled data", {16'h0, crc_data}, 32'hF000);
        repeat (2) @(negedge clk);
        #1;
        check("R7 still held", {16'h0, crc_data}, 32'hF000);
        check("R7 still no valid", {31'b0, crc_valid}, 32'd0);
        crc_ready = 1'b1;
        #0.5;
        check("R7 released valid", {31'b0, crc_valid}, 32'd1);
        @(negedge clk); #1;
        check("R6 pulse ends", {31'b0, crc_valid}, 32'd0);
        rd_chk("R6 lo after stall", 2'd1, 16'h0001);
        wr(2'd0, C_EN | C_BURST);
        rd_chk("R9 software clear", 2'd0, C_EN | C_BURST);

        // R8 go gating by CRC inputs
        crc_ready = 1'b0;
        crc_en = 1'b0;
        wr(2'd0, C_EN | C_GO);
        rd_chk("R8 crc_en low", 2'd0, C_EN);
        crc_en = 1'b1;
        crc_go = 1'b0;
        wr(2'd0, C_EN | C_GO);
        rd_chk("R8 crc_go low", 2'd0, C_EN);
        crc_go = 1'b1;
        wr(2'd0, C_EN | C_GO);
        rd_chk("R8 both high", 2'd0, C_EN | C_GO);

        // R9 crc_go falling clears go
        @(negedge clk);
        crc_go = 1'b0;
        @(negedge clk); #1;
        rd_chk("R9 crc_go drop", 2'd0, C_EN);
        crc_go = 1'b1;

        // R12 disable keeps others
        wr(2'd0, C_EN | C_TRIG | C_GO | C_REG | C_BURST);
        rd_chk("R12 armed", 2'd0, C_EN | C_TRIG | C_GO | C_REG | C_BURST);
        wr(2'd0, C_TRIG | C_GO | C_REG | C_BURST);
        #1;
        rd_chk("R12 others kept", 2'd0, C_TRIG | C_GO | C_REG | C_BURST);
        rd_chk("R12 lo kept", 2'd1, 16'h0001);
        rd_chk("R12 hi kept", 2'd2, 16'h0001);
        check("R12 no req", {31'b0, arb_req}, 32'd0);

        // R9 empty window overrides software set
        wr(2'd1, 16'h0005);
        wr(2'd2, 16'h0003);
        wr(2'd0, C_EN | C_GO);
        #1;
        rd_chk("R9 low above high", 2'd0, C_EN);

        // R9 wrap at all ones
        crc_ready = 1'b1;
        wr(2'd1, 16'hFFFF);
        wr(2'd2, 16'hFFFF);
        wr(2'd0, C_EN | C_GO);
        arb_gnt = 1'b1;
        #1;
        check("R2 last address req", {31'b0, arb_req}, 32'd1);
        @(negedge clk);
        arb_gnt = 1'b0;
        #1;
        check("R6 last word", {16'h0, crc_data}, 32'h0FFF);
        @(negedge clk); #1;
        rd_chk("R9 wrap clears go", 2'd0, C_EN);
        rd_chk("R9 lo wrapped", 2'd1, 16'h0000);
        check("R9 no req after wrap", {31'b0, arb_req}, 32'd0);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule